// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Front End

This block is the bus-facing half of a 2 KiB serial EEPROM. It watches a two-wire bus (clock line and open-drain data line), finds start and stop conditions, and decodes a device byte. That device byte holds a fixed 4-bit pattern, the top three bits of the 11-bit memory address, and a direction bit. In a write transfer the next byte sets the low eight address bits, and every later byte goes to a one-cycle write strobe on an internal memory port. In a read transfer the block shifts out bytes from the current address for as long as the master acknowledges them.

Both bus lines pass through two-flop synchronisers into the faster system clock, and all bus events are found in that domain. The memory port has no back-pressure. The write strobe acts as a single-cycle valid that the memory must always take, and read data is sampled combinationally from the presented address. A busy input from the write-commit logic makes the block deaf to the bus, so a master polling for completion gets no acknowledge. The active-low reset acts as the internal power-on reset.

Top module: `eep_bus_slave`

## Requirements
- R1: The first byte after a start is the device byte, sent MSB first. Bits 7:4 must equal 4'b1010, bits 3:1 are memory address bits 10:8, and bit 0 selects a read (1) or a write (0). Any other value in bits 7:4 gets no acknowledge, and the block ignores the bus until the next start.
- R2: For each byte it accepts (device, low address, write data), the block pulls SDA low for the whole ninth SCL clock and releases it after that clock's falling edge.
- R3: In a write transfer the second byte loads address bits 7:0. Each later byte, sampled on SCL rising edges, gives exactly one single-cycle mem_we pulse carrying that byte and the current address. The 11-bit address then increments, wrapping from 7FFh to 000h.
- R4: In a read transfer the block sends the byte at the current address, MSB first. It changes SDA only while SCL is low, after a falling edge. The address increments after each byte and wraps from 7FFh to 000h. No write strobe is issued.
- R5: After each read byte the block samples the master's ninth bit. A low bit (acknowledge) continues with the next byte. A high bit (not-acknowledge) makes the block release SDA and stay silent until the next start.
- R6: A start (SDA falling while SCL is high) aborts any byte in progress and begins a new device byte. A repeated start keeps address bits 7:0 and takes new bits 10:8 from the new device byte.
- R7: A stop (SDA rising while SCL is high) aborts any byte in progress. A partly received data byte produces no write.
- R8: While busy_i is high, the block acknowledges nothing, issues no write strobe and releases SDA. This includes a correct device byte.
- R9: While rst_n is low, sda_oe and mem_we are 0 and the bus is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Write commit in progress; the block ignores the bus |
| mem_addr | output | 11 | Current memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Single-cycle write strobe, always accepted |
| mem_rdata | input | 8 | Byte stored at mem_addr |

## Verification
The bench aims at address wrap in both page writes and sequential reads. A counter that failed to wrap would store or return the bytes after 7FFh at the wrong location. It drives a repeated start and a start and a stop in the middle of a byte. A design that kept the stale bit count would misalign the next device byte, and one that committed partial bytes would corrupt memory. It sends a wrong device pattern, holds busy, and holds reset. A block that acknowledged any of these would make polling masters think a write had finished. After a master not-acknowledge it clocks a further byte and expects all ones, which catches a slave that keeps driving data.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int HI_W   = ADDR_W - DATA_W;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_ADR, S_WR, S_ACK, S_RD, S_RACK, S_RNXT
  } eep_state_t;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/eep_bus_events.sv
module eep_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int AW   = 11,
  parameter int HI_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_hi,
  input  logic [HI_W-1:0]    hi_val,
  input  logic               ld_lo,
  input  logic [AW-HI_W-1:0] lo_val,
  input  logic               inc,
  output logic [AW-1:0]      addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (ld_hi) addr[AW-1 -: HI_W] <= hi_val;
    else if (ld_lo) addr[AW-HI_W-1:0] <= lo_val;
    else if (inc)   addr <= addr + 1'b1;
  end
endmodule

// File: rtl/eep_bus_slave.sv
module eep_bus_slave
  import eep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [1:0] sync_q;
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  eep_sync #(.W(2), .STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  eep_bus_events ev_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eep_state_t st, nxt_st;
  logic [CW-1:0]     bitcnt;
  logic [DATA_W-1:0] sh, rd_sh, rx_byte;
  logic ack_on, abort, rx_done, id_ok;
  logic ld_hi, ld_lo, inc;

  assign abort   = busy_i | stop_ev | start_ev;
  assign rx_byte = {sh[DATA_W-2:0], sda_s};
  assign rx_done = scl_rise && bitcnt == LAST;
  assign id_ok   = rx_byte[DATA_W-1 -: 4] == DEV_ID;

  always_comb begin
    ld_hi = !abort && st == S_DEV && rx_done && id_ok;
    ld_lo = !abort && st == S_ADR && rx_done;
    inc   = mem_we || (!abort && st == S_RD && scl_fall && bitcnt == LAST);
  end

  eep_addr_ctr #(.AW(ADDR_W), .HI_W(HI_W)) ctr_i (
    .clk(clk), .rst_n(rst_n),
    .ld_hi(ld_hi), .hi_val(rx_byte[HI_W:1]),
    .ld_lo(ld_lo), .lo_val(rx_byte),
    .inc(inc), .addr(mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      nxt_st    <= S_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      rd_sh     <= '0;
      ack_on    <= 1'b0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy_i || stop_ev) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        ack_on <= 1'b0;
      end else if (start_ev) begin
        st     <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        ack_on <= 1'b0;
      end else begin
        unique case (st)
          S_DEV, S_ADR, S_WR: begin
            if (scl_rise) begin
              sh     <= rx_byte;
              bitcnt <= bitcnt + 1'b1;
              if (rx_done) begin
                st <= S_ACK;
                if (st == S_DEV) begin
                  if (!id_ok) st <= S_IDLE;
                  nxt_st <= rx_byte[0] ? S_RD : S_ADR;
                end else begin
                  nxt_st <= S_WR;
                  if (st == S_WR) begin
                    mem_we    <= 1'b1;
                    mem_wdata <= rx_byte;
                  end
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                sda_oe <= 1'b1;
                ack_on <= 1'b1;
              end else begin
                ack_on <= 1'b0;
                bitcnt <= '0;
                st     <= nxt_st;
                if (nxt_st == S_RD) begin
                  rd_sh  <= mem_rdata;
                  sda_oe <= ~mem_rdata[DATA_W-1];
                end else begin
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          S_RD: begin
            if (scl_fall) begin
              if (bitcnt == LAST) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                rd_sh  <= rd_sh << 1;
                sda_oe <= ~rd_sh[DATA_W-2];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) st <= sda_s ? S_IDLE : S_RNXT;
          end
          S_RNXT: begin
            if (scl_fall) begin
              rd_sh  <= mem_rdata;
              sda_oe <= ~mem_rdata[DATA_W-1];
              bitcnt <= '0;
              st     <= S_RD;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R8: busy forces the data line free on the next cycle
  assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !sda_oe);
  // R8: no write strobe once busy has been seen for a full cycle
  assert_busy_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && $past(busy_i) |-> !mem_we);
  // R3: each write strobe lasts one cycle
  assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R4: the slave moves SDA only while the synchronised clock is low
  assert_sda_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) && !$past(busy_i) |-> !scl_s);
  // R4: a read transfer never writes
  assert_no_write_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD || st == S_RACK || st == S_RNXT) |-> !mem_we);
endmodule

// File: tb/eep_bus_slave_tb.sv
module eep_bus_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 12;
  localparam int Q = 6;
  localparam int WD_CYCLES = 150000;
  localparam int NVEC = 5;
  localparam logic [18:0] VEC [NVEC] = '{
    {11'h000, 8'h3C}, {11'h7FF, 8'hA5}, {11'h3A5, 8'h00},
    {11'h400, 8'hFF}, {11'h1E7, 8'h96}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, mem_we, sda_bus;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  bit [7:0] mem [2048];
  int we_count = 0;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdata;
    we_count <= we_count + 1;
  end

  eep_bus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .busy_i(busy), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus;
    tick(HALF - Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(HALF); sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(HALF); sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(mack);
  endtask

  task automatic write_bytes(input logic [10:0] a, input logic [7:0] d0, d1, d2, input int n);
    logic ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack); check("R2 device ack", ack, 0);
    send_byte(a[7:0], ack); check("R2 address ack", ack, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); check("R2 data ack", ack, 0);
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [10:0] a, input int n, output logic [7:0] r [3]);
    logic ack;
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack); check("R2 device ack", ack, 0);
    send_byte(a[7:0], ack); check("R2 address ack", ack, 0);
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b1}, ack); check("R6 repeated start ack", ack, 0);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, r[i]);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] r [3];
    logic [7:0] b;
    int wc;
    tick(5);
    check("R9 reset sda_oe", sda_oe, 0);
    check("R9 reset mem_we", mem_we, 0);
    rst_n = 1'b1;
    tick(5);

    // table of single-byte writes followed by random reads
    for (int i = 0; i < NVEC; i++) begin
      wc = we_count;
      write_bytes(VEC[i][18:8], VEC[i][7:0], 8'h00, 8'h00, 1);
      check("R3 stored byte", mem[VEC[i][18:8]], VEC[i][7:0]);
      check("R3 one strobe", we_count, wc + 1);
      read_seq(VEC[i][18:8], 1, r);
      bus_stop();
      check("R4 read back", r[0], VEC[i][7:0]);
    end

    // R3 page write across the top of memory
    wc = we_count;
    write_bytes(11'h7FE, 8'h11, 8'h22, 8'h33, 3);
    check("R3 page 7FE", mem[11'h7FE], 8'h11);
    check("R3 page 7FF", mem[11'h7FF], 8'h22);
    check("R3 page wrap 000", mem[11'h000], 8'h33);
    check("R3 page strobes", we_count, wc + 3);

    // R4/R5 sequential read with wrap, then silence after nack
    read_seq(11'h7FE, 3, r);
    check("R4 seq 7FE", r[0], 8'h11);
    check("R4 seq 7FF", r[1], 8'h22);
    check("R4 seq wrap 000", r[2], 8'h33);
    recv_byte(1'b1, b);
    check("R5 released after nack", b, 8'hFF);
    bus_stop();

    // R1 wrong device pattern
    wc = we_count;
    bus_start();
    send_byte(8'b1011_0000, ack); check("R1 wrong id nack", ack, 1);
    send_byte(8'h10, ack); check("R1 ignored after mismatch", ack, 1);
    bus_stop();
    check("R1 no write", we_count, wc);

    // R8 busy
    busy = 1'b1;
    bus_start();
    send_byte(8'b1010_0000, ack); check("R8 busy nack", ack, 1);
    send_byte(8'h10, ack); check("R8 busy addr nack", ack, 1);
    bus_stop();
    busy = 1'b0;
    check("R8 no write while busy", we_count, wc);

    // R7 stop in the middle of a data byte
    bus_start();
    send_byte(8'b1010_0000, ack); check("R2 device ack", ack, 0);
    send_byte(8'h10, ack); check("R2 address ack", ack, 0);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    check("R7 no partial write", we_count, wc);
    check("R7 memory untouched", mem[11'h010], 8'h00);

    // R6 start in the middle of a byte
    bus_start();
    send_byte(8'b1010_0100, ack); check("R2 device ack", ack, 0);
    send_byte(8'h20, ack); check("R2 address ack", ack, 0);
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    bus_start();
    send_byte(8'b1010_0100, ack); check("R6 ack after abort", ack, 0);
    send_byte(8'h21, ack); check("R6 address ack", ack, 0);
    send_byte(8'h99, ack); check("R6 data ack", ack, 0);
    bus_stop();
    check("R6 write after restart", mem[11'h221], 8'h99);
    check("R6 single strobe", we_count, wc + 1);

    // R9 held in reset
    wc = we_count;
    rst_n = 1'b0;
    bus_start();
    send_byte(8'b1010_0000, ack); check("R9 no ack in reset", ack, 1);
    send_byte(8'h05, ack);
    send_byte(8'h77, ack);
    bus_stop();
    check("R9 no write in reset", we_count, wc);
    rst_n = 1'b1;
    tick(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule